// File: doc/BRIEF.md
# Deferred Soft Reset Controller

This block lets software reset a MAC-style core by writing a request bit, but holds the reset back until the transmit and receive DMA engines are both idle. That way, no in-flight transfer is cut off. While the request waits, the same bit reads back as 1. It reads 0 once the core has taken its reset. The reset is a single-cycle pulse. It returns the core configuration register to its default value, and this includes the full-duplex bit.

Two things sit outside the software reset domain:
- The management sub-block has its own reset output, which only the hardware reset drives.
- A sticky host-error flag is set by a descriptor-error strobe and drives an interrupt. Only the hardware reset clears it.

The hardware reset is active-low. It asserts asynchronously and is released through a two-stage synchronizer. It also cancels any request that is still waiting.

The sequencer is a three-state machine:
- `ST_IDLE` (no request) moves to `ST_WAIT` on a write of 1 to the request bit.
- `ST_WAIT` (request pending) moves to `ST_PULSE` on the first clock edge where both DMA idle inputs are high.
- `ST_PULSE` (core reset asserted) always moves back to `ST_IDLE` on the next edge.

Top module: `srst_ctrl`

## Requirements
- R1: A register write to address 0 with data bit 0 set makes the pending bit (address 0 read, bit 0) read 1 from the cycle after the write. It stays 1 until the pulse has completed.
- R2: `core_rst` pulses only after a clock edge at which `tx_dma_idle` and `rx_dma_idle` were both high while a request was pending. While either input is low, no pulse occurs and the request stays pending.
- R3: The core reset pulse lasts exactly one clock cycle. It begins in the cycle after the edge at which the idle condition was seen.
- R4: The pending bit reads 0 in the cycle after the pulse.
- R5: The pulse returns the configuration register (address 1) to its default of 0x04 in the cycle after the pulse. Bit 0 of this register is the full-duplex bit, with default 0. Before that cycle, the configuration register keeps any value that was written.
- R6: The following writes have no effect:
  - a write to address 0 with data bit 0 clear;
  - a write of 1 while a request is pending;
  - a write of 1 during the pulse.

  None of these starts a second pulse or extends the first.
- R7: A one-cycle `host_err_strobe` sets the host-error flag. The flag reads as bit 0 of address 2 and drives `host_err_irq` from the next cycle. A soft reset leaves the flag set.
- R8: While `rst_n` is low, the block is held in reset:
  - `core_rst` is 1 and `mgmt_rst_n` is 0, asynchronously;
  - the pending bit, the host-error flag and `host_err_irq` read 0;
  - the configuration register holds its default.

  After `rst_n` rises, both reset outputs are released on the second clock edge. A request that was pending produces no pulse.
- R9: `mgmt_rst_n` stays 1 across a soft reset, including the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active-low, asynchronous assert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 configuration, 2 status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| tx_dma_idle | input | 1 | Transmit DMA engine is idle |
| rx_dma_idle | input | 1 | Receive DMA engine is idle |
| host_err_strobe | input | 1 | One-cycle descriptor-error indication |
| core_rst | output | 1 | Active-high reset to the MAC core (soft pulse or hardware reset) |
| mgmt_rst_n | output | 1 | Active-low reset to the management sub-block (hardware only) |
| cfg_out | output | DATA_W | Current configuration register value to the core |
| host_err_irq | output | 1 | Interrupt, follows the sticky host-error flag |

## Verification
The bench sweeps the number of busy cycles from zero to four, with the transmit engine busy, the receive engine busy, and both busy. In each case it checks the exact cycle of the pulse and the clearing of the pending bit. A design that pulsed on only one idle input, or that pulsed early, would show the pulse in the wrong cycle. The bench also repeats the request write while a request is pending and during the pulse. A design that restarted the sequence would show a second pulse or a pending bit that stays up too long. A hardware reset is applied while a request is pending. A design that did not cancel the request would pulse after the release. The bench also confirms that the error flag survives every soft reset, which a design placing that flag in the wrong reset domain would lose.

// File: rtl/srst_pkg.sv
package srst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } srst_state_t;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_CFG  = 1;
    localparam int unsigned ADDR_STAT = 2;
endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srst_fsm.sv
module srst_fsm
    import srst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic tx_idle,
    input  logic rx_idle,
    output logic pending,
    output logic core_pulse
);
    srst_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_set)            state_d = ST_WAIT;
            ST_WAIT:  if (tx_idle && rx_idle) state_d = ST_PULSE;
            ST_PULSE:                         state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending    = 1'b0;
        core_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin pending = 1'b0; core_pulse = 1'b0; end
            ST_WAIT:  begin pending = 1'b1; core_pulse = 1'b0; end
            ST_PULSE: begin pending = 1'b1; core_pulse = 1'b1; end
            default:  begin pending = 1'b0; core_pulse = 1'b0; end
        endcase
    end
endmodule

// File: rtl/srst_cfg_reg.sv
module srst_cfg_reg #(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= CFG_DEFAULT;
        else if (soft_clr) cfg_q <= CFG_DEFAULT;
        else if (wr_en)    cfg_q <= wr_data;
    end
endmodule

// File: rtl/srst_err_flag.sv
module srst_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_strobe,
    output logic flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (set_strobe) flag_q <= 1'b1;
    end
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
    import srst_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_dma_idle,
    input  logic              rx_dma_idle,
    input  logic              host_err_strobe,
    output logic              core_rst,
    output logic              mgmt_rst_n,
    output logic [DATA_W-1:0] cfg_out,
    output logic              host_err_irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    logic              hw_rst_n;
    logic              pending;
    logic              core_pulse;
    logic              host_err;
    logic [DATA_W-1:0] cfg_q;
    logic              req_set;
    logic              cfg_wr;

    assign req_set = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
    assign cfg_wr  = reg_wr && (reg_addr == A_CFG);

    srst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_n_sync (hw_rst_n)
    );

    srst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (hw_rst_n),
        .req_set    (req_set),
        .tx_idle    (tx_dma_idle),
        .rx_idle    (rx_dma_idle),
        .pending    (pending),
        .core_pulse (core_pulse)
    );

    srst_cfg_reg #(.DATA_W(DATA_W), .CFG_DEFAULT(CFG_DEFAULT)) u_cfg (
        .clk      (clk),
        .rst_n    (hw_rst_n),
        .soft_clr (core_pulse),
        .wr_en    (cfg_wr),
        .wr_data  (reg_wdata),
        .cfg_q    (cfg_q)
    );

    srst_err_flag u_err (
        .clk        (clk),
        .rst_n      (hw_rst_n),
        .set_strobe (host_err_strobe),
        .flag_q     (host_err)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)      reg_rdata[0] = pending;
        else if (reg_addr == A_CFG)  reg_rdata    = cfg_q;
        else if (reg_addr == A_STAT) reg_rdata[0] = host_err;
    end

    assign core_rst     = core_pulse | ~hw_rst_n;
    assign mgmt_rst_n   = hw_rst_n;
    assign cfg_out      = cfg_q;
    assign host_err_irq = host_err;
endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk #(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'h04
) (
    input logic              clk,
    input logic              mgmt_rst_n,
    input logic              core_rst,
    input logic              pending,
    input logic              tx_dma_idle,
    input logic              rx_dma_idle,
    input logic              host_err_strobe,
    input logic              host_err_irq,
    input logic [DATA_W-1:0] cfg_q
);
    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        (pending && !core_rst) |=> pending);
    // R2
    idle_gate_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        core_rst |-> $past(tx_dma_idle && rx_dma_idle));
    // R3
    one_cycle_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        core_rst |=> !core_rst);
    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        core_rst |=> !pending);
    // R5
    cfg_default_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        core_rst |=> (cfg_q == CFG_DEFAULT));
    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        host_err_strobe |=> host_err_irq);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!mgmt_rst_n)
        host_err_irq |=> host_err_irq);
endmodule

bind srst_ctrl srst_ctrl_chk #(.DATA_W(DATA_W), .CFG_DEFAULT(CFG_DEFAULT)) u_chk (
    .clk             (clk),
    .mgmt_rst_n      (mgmt_rst_n),
    .core_rst        (core_rst),
    .pending         (pending),
    .tx_dma_idle     (tx_dma_idle),
    .rx_dma_idle     (rx_dma_idle),
    .host_err_strobe (host_err_strobe),
    .host_err_irq    (host_err_irq),
    .cfg_q           (cfg_q)
);

// File: tb/srst_ctrl_test.sv
module srst_ctrl_test;
    localparam int          DW  = 8;
    localparam int          AW  = 2;
    localparam logic [7:0]  DEF = 8'h04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          tx_dma_idle = 1'b1;
    logic          rx_dma_idle = 1'b1;
    logic          host_err_strobe = 1'b0;
    logic          core_rst;
    logic          mgmt_rst_n;
    logic [DW-1:0] cfg_out;
    logic          host_err_irq;

    int total = 0;
    int bad = 0;

    srst_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CFG_DEFAULT(DEF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_dma_idle(tx_dma_idle), .rx_dma_idle(rx_dma_idle),
        .host_err_strobe(host_err_strobe), .core_rst(core_rst),
        .mgmt_rst_n(mgmt_rst_n), .cfg_out(cfg_out), .host_err_irq(host_err_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        reg_addr = AW'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic nxt();
        @(negedge clk);
        reg_wr = 1'b0;
        host_err_strobe = 1'b0;
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] wval;
        // R8 reset state
        repeat (3) @(negedge clk);
        rd(0, v); chk("R8 pending in reset", v[0], 0);
        rd(1, v); chk("R8 cfg in reset", v, DEF);
        rd(2, v); chk("R8 err in reset", v[0], 0);
        chk("R8 core_rst in reset", core_rst, 1);
        chk("R8 mgmt_rst_n in reset", mgmt_rst_n, 0);
        chk("R8 irq in reset", host_err_irq, 0);
        rst_n = 1'b1;
        nxt();
        chk("R8 mgmt still held after one edge", mgmt_rst_n, 0);
        nxt();
        chk("R8 mgmt released", mgmt_rst_n, 1);
        chk("R8 core released", core_rst, 0);

        // R6 write 0 does nothing
        reg_addr = 0; reg_wdata = 8'h00; reg_wr = 1'b1;
        nxt();
        for (int k = 0; k < 4; k++) begin
            rd(0, v);
            chk("R6 write0 pending", v[0], 0);
            chk("R6 write0 core_rst", core_rst, 0);
            nxt();
        end

        // R7 error flag
        rd(2, v); chk("R7 err before strobe", v[0], 0);
        host_err_strobe = 1'b1;
        nxt();
        rd(2, v); chk("R7 err set", v[0], 1);
        chk("R7 irq set", host_err_irq, 1);

        // Sweep: mode 0 tx busy, 1 rx busy, 2 both busy; n busy cycles
        for (int mode = 0; mode < 3; mode++) begin
            for (int n = 0; n <= 4; n++) begin
                wval = 8'hA1 | DW'(n << 1);
                reg_addr = 1; reg_wdata = wval; reg_wr = 1'b1;
                nxt();
                rd(1, v); chk("R5 cfg written", v, wval);
                // request with busy pattern
                tx_dma_idle = !(n > 0 && mode != 1);
                rx_dma_idle = !(n > 0 && mode != 0);
                reg_addr = 0; reg_wdata = 8'h01; reg_wr = 1'b1;
                nxt();
                for (int j = 0; j <= n + 3; j++) begin
                    rd(0, v);
                    chk("R1/R4 pending", v[0], (j <= n + 1) ? 1 : 0);
                    chk("R2/R3 core_rst timing", core_rst, (j == n + 1) ? 1 : 0);
                    chk("R9 mgmt_rst_n stays", mgmt_rst_n, 1);
                    chk("R7 irq survives", host_err_irq, 1);
                    rd(1, v);
                    chk("R5 cfg value", v, (j <= n + 1) ? wval : DEF);
                    if (j >= n) begin
                        tx_dma_idle = 1'b1;
                        rx_dma_idle = 1'b1;
                    end
                    if (j == 0 || (mode == 2 && j == n + 1)) begin
                        // R6 repeated request while pending or in pulse
                        reg_addr = 0; reg_wdata = 8'h01; reg_wr = 1'b1;
                        @(negedge clk);
                        reg_wr = 1'b0;
                    end else begin
                        nxt();
                    end
                end
                rd(2, v); chk("R7 err after soft reset", v[0], 1);
            end
        end

        // R8 hardware reset cancels pending request
        tx_dma_idle = 1'b0; rx_dma_idle = 1'b0;
        reg_addr = 0; reg_wdata = 8'h01; reg_wr = 1'b1;
        nxt();
        nxt();
        rd(0, v); chk("R2 pending while busy", v[0], 1);
        chk("R2 no pulse while busy", core_rst, 0);
        #3 rst_n = 1'b0;
        #1;
        chk("R8 async core_rst", core_rst, 1);
        chk("R8 async mgmt", mgmt_rst_n, 0);
        rd(0, v); chk("R8 pending cleared", v[0], 0);
        rd(2, v); chk("R8 err cleared", v[0], 0);
        chk("R8 irq cleared", host_err_irq, 0);
        tx_dma_idle = 1'b1; rx_dma_idle = 1'b1;
        nxt();
        rst_n = 1'b1;
        nxt();
        nxt();
        for (int k = 0; k < 4; k++) begin
            chk("R8 no pulse after hw reset", core_rst, 0);
            rd(0, v); chk("R8 no pending after hw reset", v[0], 0);
            nxt();
        end
        rd(1, v); chk("R8 cfg default after hw reset", v, DEF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule